// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block orders the switching of an LCD panel's supply rail and its logic signals so that the panel is never powered while its drive signals are idle. It counts whole frames from a single-cycle frame-start strobe. A software power-save field, a hardware power-save pin and a power-override bit can each ask for power to be removed.

When a power-save request arrives, panel power is kept until the next frame boundary and then removed. The logic signals keep running for a further 127 frames so that the supply can discharge. After that the signals are stopped as well. When the request is withdrawn, the signals return in the next cycle and power follows at the next frame boundary.

The override bit lets software run the power-down and power-up order itself. While the latched bit is set, power is held off and the signals are left under power-save control. The control word is a 4-bit input driven by a register elsewhere. Its bits are: bit 3 override, bit 2 hardware save enable, bits 1:0 software save field. That register resets to 4'b0011.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `panel_sig_o` and `panel_pwr_o` are both 1. The latched override state is 0.
- R2: A software field `ctrl_i[1:0]` of 2'b00 requests power save. The values 2'b01, 2'b10 and 2'b11 all mean normal operation.
- R3: `hw_save_i` requests power save only while `ctrl_i[2]` is 1. While `ctrl_i[2]` is 0, the pin has no effect on either output.
- R4: After a request, `panel_pwr_o` stays 1 until a clock edge with `frame_i` high. It is 0 from the cycle after that edge. `panel_sig_o` stays 1.
- R5: After power drops, `panel_sig_o` stays 1 through 126 further frame strobes. It goes to 0 in the cycle after the 127th. This makes 128 strobes in total from the request.
- R6: When the request is withdrawn after power has dropped, `panel_sig_o` is 1 in the next cycle and `panel_pwr_o` returns after the next frame strobe. A request that comes back before that strobe restarts the 127-frame hold.
- R7: A request withdrawn before its first frame strobe leaves both outputs at 1 throughout.
- R8: `ctrl_i[3]` is latched only on frame strobes. From the cycle after a strobe that sees it at 1, `panel_pwr_o` is 0. Power is restored by a strobe that sees it at 0, provided power save is not active.
- R9: `panel_pwr_o` is never 1 while `panel_sig_o` is 0.
- R10: Frame strobes with no request and no override leave both outputs at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Single-cycle frame-start strobe |
| ctrl_i | input | 4 | Control word: [3] override, [2] hardware save enable, [1:0] software save field |
| hw_save_i | input | 1 | Hardware power-save request pin |
| panel_pwr_o | output | 1 | Panel supply enable |
| panel_sig_o | output | 1 | Panel logic signal enable |

## Verification
A corrupted state register shows up at once as an illegal pair of outputs, such as power on with signals off, or as a transition between frame strobes. A wrong frame count shows only when `panel_sig_o` falls, 127 strobes after power drops, so the bench runs complete holds with the exact strobe count. A lost override latch shows on `panel_pwr_o` one cycle after the next strobe. Random phases keep a frame-accurate model alongside the design and compare both outputs every cycle.

// File: rtl/lcd_pwr_seq_pkg.sv
package lcd_pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_NORM = 3'd0,  // powered, signals on
    ST_OFFW = 3'd1,  // request seen, waiting for frame to drop power
    ST_HOLD = 3'd2,  // power off, signals held while supply discharges
    ST_SAVE = 3'd3,  // fully off
    ST_ONW  = 3'd4   // signals back, waiting for frame to restore power
  } seq_state_e;

  typedef struct packed {
    logic       ovr;
    logic       hw_en;
    logic [1:0] sw_save;
  } ctrl_t;

  localparam logic [1:0] SW_SAVE_REQ = 2'b00;

endpackage

// File: rtl/lcd_pwr_req.sv
module lcd_pwr_req
  import lcd_pwr_seq_pkg::*;
(
  input  ctrl_t ctrl_i,
  input  logic  hw_save_i,
  output logic  save_req_o
);

  logic sw_req;
  logic hw_req;

  assign sw_req     = (ctrl_i.sw_save == SW_SAVE_REQ);
  assign hw_req     = ctrl_i.hw_en & hw_save_i;
  assign save_req_o = sw_req | hw_req;

endmodule

// File: rtl/lcd_frame_cnt.sv
module lcd_frame_cnt #(
  parameter int unsigned LIMIT = 127
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i)        cnt_q <= '0;
    else if (inc_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

endmodule

// File: rtl/lcd_pwr_ovr.sv
module lcd_pwr_ovr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic ovr_i,
  output logic ovr_o
);

  logic ovr_q;

  // override takes effect only at frame boundaries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= 1'b0;
    else if (frame_i) ovr_q <= ovr_i;
  end

  assign ovr_o = ovr_q;

endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
  import lcd_pwr_seq_pkg::*;
#(
  parameter int unsigned HOLD_FRAMES = 127
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic save_req_i,
  output logic pwr_on_o,
  output logic sig_on_o
);

  seq_state_e st_q, st_d;
  logic       cnt_clr;
  logic       cnt_inc;
  logic       cnt_done;

  lcd_frame_cnt #(.LIMIT(HOLD_FRAMES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .done_o (cnt_done)
  );

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (st_q)
      ST_NORM: if (save_req_i) st_d = ST_OFFW;
      ST_OFFW: begin
        if (!save_req_i) st_d = ST_NORM;
        else if (frame_i) begin
          st_d    = ST_HOLD;
          cnt_clr = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!save_req_i) st_d = ST_ONW;
        else if (frame_i) begin
          if (cnt_done) st_d = ST_SAVE;
          else          cnt_inc = 1'b1;
        end
      end
      ST_SAVE: if (!save_req_i) st_d = ST_ONW;
      ST_ONW: begin
        // renewed request restarts discharge from the top
        if (save_req_i) begin
          st_d    = ST_HOLD;
          cnt_clr = 1'b1;
        end else if (frame_i) st_d = ST_NORM;
      end
      default: st_d = ST_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_NORM;
    else         st_q <= st_d;
  end

  assign sig_on_o = (st_q != ST_SAVE);
  assign pwr_on_o = (st_q == ST_NORM) || (st_q == ST_OFFW);

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_pwr_seq_pkg::*;
#(
  parameter int unsigned HOLD_FRAMES = 127
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic [3:0] ctrl_i,
  input  logic       hw_save_i,
  output logic       panel_pwr_o,
  output logic       panel_sig_o
);

  ctrl_t ctrl;
  logic  save_req;
  logic  ovr_eff;
  logic  seq_pwr;
  logic  seq_sig;

  assign ctrl = ctrl_t'(ctrl_i);

  lcd_pwr_req u_req (
    .ctrl_i     (ctrl),
    .hw_save_i  (hw_save_i),
    .save_req_o (save_req)
  );

  lcd_pwr_ovr u_ovr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .ovr_i   (ctrl.ovr),
    .ovr_o   (ovr_eff)
  );

  lcd_pwr_fsm #(.HOLD_FRAMES(HOLD_FRAMES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .save_req_i (save_req),
    .pwr_on_o   (seq_pwr),
    .sig_on_o   (seq_sig)
  );

  assign panel_sig_o = seq_sig;
  assign panel_pwr_o = seq_pwr & ~ovr_eff;

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic [3:0] ctrl_i,
  input logic       hw_save_i,
  input logic       panel_pwr_o,
  input logic       panel_sig_o
);

  logic req_now;
  assign req_now = (ctrl_i[1:0] == 2'b00) || (ctrl_i[2] && hw_save_i);

  // R9
  a_r9_sig_covers_pwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_pwr_o |-> panel_sig_o);

  // R4 R8: power only drops on a frame edge
  a_r4_pwr_fall_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(panel_pwr_o) |-> $past(frame_i));

  // R6: power only returns on a frame edge
  a_r6_pwr_rise_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(panel_pwr_o) |-> $past(frame_i));

  // R5: signals stop on a frame edge, after power is gone, under a live request
  a_r5_sig_fall_after_pwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(panel_sig_o) |-> ($past(frame_i) && !$past(panel_pwr_o) && $past(req_now)));

  // R6: signals come back before power
  a_r6_sig_rise_before_pwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(panel_sig_o) |-> !panel_pwr_o);

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_i     (frame_i),
  .ctrl_i      (ctrl_i),
  .hw_save_i   (hw_save_i),
  .panel_pwr_o (panel_pwr_o),
  .panel_sig_o (panel_sig_o)
);

// File: tb/sim_lcd_pwr_seq.sv
module sim_lcd_pwr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 127;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic [3:0] ctrl = 4'b0011;
  logic       hw = 1'b0;
  logic       pwr;
  logic       sig;

  int checks = 0;
  int errors = 0;

  // reference model state: 0 norm, 1 off-wait, 2 hold, 3 save, 4 on-wait
  int m_st = 0;
  int m_cnt = 0;
  bit m_ovr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_pwr_seq #(.HOLD_FRAMES(HOLD)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frame_i     (frame),
    .ctrl_i      (ctrl),
    .hw_save_i   (hw),
    .panel_pwr_o (pwr),
    .panel_sig_o (sig)
  );

  function automatic bit f_req(logic [3:0] c, logic h);
    return (c[1:0] == 2'b00) || (c[2] && h);
  endfunction

  function automatic bit f_sig(int st);
    return st != 3;
  endfunction

  function automatic bit f_pwr(int st, bit ov);
    return ((st == 0) || (st == 1)) && !ov;
  endfunction

  task automatic model_edge();
    bit r = f_req(ctrl, hw);
    case (m_st)
      0: if (r) m_st = 1;
      1: if (!r) m_st = 0; else if (frame) begin m_st = 2; m_cnt = 0; end
      2: if (!r) m_st = 4;
         else if (frame) begin
           if (m_cnt == HOLD - 1) m_st = 3; else m_cnt++;
         end
      3: if (!r) m_st = 4;
      4: if (r) begin m_st = 2; m_cnt = 0; end else if (frame) m_st = 0;
      default: m_st = 0;
    endcase
    if (frame) m_ovr = ctrl[3];
  endtask

  task automatic check(bit got, bit exp, string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock with given frame strobe; inputs already set
  task automatic step(bit f);
    frame = f;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic check_model(string tag);
    check(sig, f_sig(m_st), {tag, " sig"});
    check(pwr, f_pwr(m_st, m_ovr), {tag, " pwr"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 during reset
    check(sig, 1'b1, "R1 reset sig");
    check(pwr, 1'b1, "R1 reset pwr");
    rst_n = 1'b1;
    @(negedge clk);
    check(sig, 1'b1, "R1 post-reset sig");
    check(pwr, 1'b1, "R1 post-reset pwr");

    // R2 R10: non-zero software codes are normal
    ctrl = 4'b0001; step(1'b1); step(1'b0);
    check_model("R2 code01");
    check(pwr, 1'b1, "R10 frame idle pwr");
    ctrl = 4'b0010; step(1'b1);
    check_model("R2 code10");
    ctrl = 4'b0011; step(1'b1);
    check(sig & pwr, 1'b1, "R10 idle both on");

    // R3: pin ignored with enable clear
    hw = 1'b1; ctrl = 4'b0011;
    step(1'b0); step(1'b1); step(1'b0);
    check(pwr, 1'b1, "R3 pin masked pwr");
    check(sig, 1'b1, "R3 pin masked sig");

    // R3 R4: enabled pin, power drops only at frame
    ctrl = 4'b0111;
    step(1'b0); step(1'b0);
    check(pwr, 1'b1, "R4 pwr before frame");
    step(1'b1);
    check(pwr, 1'b0, "R4 pwr after frame");
    check(sig, 1'b1, "R4 sig kept");
    // R6: withdraw during hold
    hw = 1'b0;
    step(1'b0);
    check(sig, 1'b1, "R6 sig on");
    check(pwr, 1'b0, "R6 pwr waits");
    step(1'b1);
    check(pwr, 1'b1, "R6 pwr back");
    check_model("R6 model");

    // R7: withdraw before first frame
    ctrl = 4'b0000; step(1'b0);
    ctrl = 4'b0011; step(1'b0); step(1'b1);
    check(pwr, 1'b1, "R7 pwr untouched");
    check(sig, 1'b1, "R7 sig untouched");

    // R5: full hold with exact strobe count
    ctrl = 4'b0000; step(1'b0); step(1'b1);
    check(pwr, 1'b0, "R5 pwr dropped");
    for (int i = 0; i < HOLD - 1; i++) begin
      step(1'b1);
      step(1'b0);
    end
    check(sig, 1'b1, "R5 sig after 126");
    step(1'b1);
    check(sig, 1'b0, "R5 sig after 127");
    check(pwr, 1'b0, "R9 pwr off in save");
    ctrl = 4'b0011; step(1'b0);
    check(sig, 1'b1, "R6 exit sig first");
    check(pwr, 1'b0, "R6 exit pwr waits");
    step(1'b1);
    check(pwr, 1'b1, "R6 exit pwr back");

    // R8: override latched at frame
    ctrl = 4'b1011; step(1'b0);
    check(pwr, 1'b1, "R8 no frame yet");
    step(1'b1);
    check(pwr, 1'b0, "R8 forced off");
    check(sig, 1'b1, "R8 sig kept");
    ctrl = 4'b0011; step(1'b0);
    check(pwr, 1'b0, "R8 held until frame");
    step(1'b1);
    check(pwr, 1'b1, "R8 released");

    // random phase against the model
    for (int n = 0; n < 6000; n++) begin
      if (($urandom % 150) == 0) ctrl[1:0] = 2'($urandom);
      if (($urandom % 300) == 0) ctrl[3] = ~ctrl[3];
      if (($urandom % 100) == 0) ctrl[2] = ~ctrl[2];
      if (($urandom % 120) == 0) hw = ~hw;
      step(($urandom % 3) == 0);
      check_model("R4 R5 R6 R8 random");
      check(!(pwr && !sig), 1'b1, "R9 order");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule